// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a two-channel PCM stream, carried on a bit clock, a word-select line and a serial data line, into parallel 24-bit left and right samples. A 3-bit format code selects the framing: right-aligned words of 16, 20 or 24 bits, left-aligned 24-bit words, or I2S framing with its one-bit delay. Shorter words come out left-justified in the 24-bit output, so the sign stays in bit 23 and the unused low bits read as zero.

The three serial inputs are oversampled by a faster system clock. They pass through a resynchronizer, and each rising edge of the bit clock is detected as a single-cycle enable. Once a left and a right word have both been captured, the two outputs update together and a one-cycle strobe is raised. Right-aligned modes keep a running window of the most recent bits and take the word when word-select changes. For this reason they work with any number of bit clocks per half-frame that is at least the word length.

Top module: `serial_audio_rx`

## Requirements
- R1: `fmt_i` selects the framing: 000 16-bit right-aligned, 001 20-bit right-aligned, 010 24-bit left-aligned, 011 24-bit I2S, 100 24-bit right-aligned. It is changed only while `rst_ni` is low.
- R2: `sd_i` is taken on rising edges of `sck_i`, most significant bit first. The two's complement bit pattern reaches the output unchanged, and `valid_o` rises only in the cycle after a detected rising bit-clock edge.
- R3: In the left-aligned mode the word is the 24 bits that begin with the first bit clock after a `ws_i` change. A half-frame needs at least 24 bit clocks. Later bits are ignored, and 16- or 20-bit words padded with zeros pass through as they are.
- R4: In I2S mode the MSB comes on the second bit clock after a `ws_i` change, and `ws_i` low marks the left channel. With exactly 24 bit clocks per half-frame, the LSB falls on the first bit clock of the next half-frame.
- R5: In the right-aligned modes the word is the last N bits before a `ws_i` change (N = 16, 20 or 24). Bits earlier in the half-frame are ignored, for any half-frame of at least N bit clocks.
- R6: 16-bit words appear in output bits [23:8] with [7:0] zero, and 20-bit words appear in bits [23:4] with [3:0] zero.
- R7: `valid_o` is a one-cycle pulse, raised once per stereo frame after the right word is captured. `left_o` and `right_o` change only in a cycle where `valid_o` is high.
- R8: In every mode except I2S, `ws_i` high marks the left channel.
- R9: During reset `left_o`, `right_o` and `valid_o` are zero. No word is taken until a `ws_i` change has been seen after reset, and the partial half-frame before that change is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, faster than four times the bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fmt_i | input | 3 | Framing select, see R1 |
| sck_i | input | 1 | Serial bit clock, oversampled |
| ws_i | input | 1 | Word-select / channel framing line |
| sd_i | input | 1 | Serial data, MSB first |
| left_o | output | 24 | Left sample, left-justified |
| right_o | output | 24 | Right sample, left-justified |
| valid_o | output | 1 | One-cycle strobe when a stereo pair is updated |

## Verification
The assertions check several properties on every cycle: the strobe lasts one cycle, it only follows a detected bit-clock edge, the outputs hold between strobes, and the low bits are zero in the 16- and 20-bit modes. The bench scenarios are needed for the rest. They check that the right bits are taken in each framing: the position of the word relative to the word-select change, the one-bit I2S delay including the LSB that lands in the next half-frame, the independence of right-aligned capture from half-frame length, the channel polarity, and discarding of the stream before the first word-select change. Every stream begins with the most negative and the most positive word for its width.

// File: rtl/serial_audio_rx_pkg.sv
package serial_audio_rx_pkg;
  typedef enum logic [2:0] {
    FMT_L16   = 3'b000,
    FMT_L20   = 3'b001,
    FMT_MSB24 = 3'b010,
    FMT_I2S24 = 3'b011,
    FMT_L24   = 3'b100
  } fmt_e;
endpackage

// File: rtl/serial_audio_rx_sync.sv
module serial_audio_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic ws_i,
  input  logic sd_i,
  output logic rise_o,
  output logic ws_o,
  output logic sd_o
);
  localparam int NSIG = 3;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] synced;
  logic            sck_d;

  assign raw = {sck_i, ws_i, sd_i};

  for (genvar g = 0; g < NSIG; g++) begin : g_chain
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_d <= 1'b0;
    else         sck_d <= synced[2];
  end

  assign rise_o = synced[2] & ~sck_d;
  assign ws_o   = synced[1];
  assign sd_o   = synced[0];
endmodule

// File: rtl/serial_audio_rx_frame.sv
module serial_audio_rx_frame
  import serial_audio_rx_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              ws_i,
  input  logic              sd_i,
  input  logic [2:0]        fmt_i,
  output logic              cap_o,
  output logic              cap_left_o,
  output logic [DATA_W-1:0] cap_word_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] MSB_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] I2S_LAST = CNT_W'(DATA_W);

  logic [DATA_W-1:0] shift_q, shifted, word;
  logic [CNT_W-1:0]  cnt_q, idx;
  logic              ws_q, primed_q, synced_q;
  logic              ws_edge, hit, chan_ws, i2s;

  always_comb begin
    ws_edge = primed_q && (ws_i != ws_q);
    if (ws_edge)               idx = '0;
    else if (cnt_q == CNT_MAX) idx = cnt_q;
    else                       idx = cnt_q + 1'b1;
    shifted = {shift_q[DATA_W-2:0], sd_i};
    hit     = 1'b0;
    word    = shifted;
    chan_ws = ws_i;
    i2s     = 1'b0;
    case (fmt_i)
      FMT_L16: begin
        hit = ws_edge; chan_ws = ws_q;
        word = {shift_q[15:0], {(DATA_W-16){1'b0}}};
      end
      FMT_L20: begin
        hit = ws_edge; chan_ws = ws_q;
        word = {shift_q[19:0], {(DATA_W-20){1'b0}}};
      end
      FMT_L24: begin
        hit = ws_edge; chan_ws = ws_q; word = shift_q;
      end
      FMT_I2S24: begin
        i2s = 1'b1;
        // LSB may land on the first bit of the following half-frame
        if (ws_edge) begin hit = (cnt_q == MSB_LAST); chan_ws = ws_q; end
        else         hit = (idx == I2S_LAST);
      end
      default: hit = !ws_edge && (idx == MSB_LAST);
    endcase
  end

  assign cap_o      = bit_en_i && synced_q && hit;
  assign cap_left_o = i2s ? !chan_ws : chan_ws;
  assign cap_word_o = word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q  <= '0;
      cnt_q    <= '0;
      ws_q     <= 1'b0;
      primed_q <= 1'b0;
      synced_q <= 1'b0;
    end else if (bit_en_i) begin
      shift_q  <= shifted;
      cnt_q    <= idx;
      ws_q     <= ws_i;
      primed_q <= 1'b1;
      if (ws_edge) synced_q <= 1'b1;
    end
  end
endmodule

// File: rtl/serial_audio_rx_out.sv
module serial_audio_rx_out #(
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              cap_left_i,
  input  logic [DATA_W-1:0] cap_word_i,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (cap_i) begin
        if (cap_left_i) begin
          stage_q <= cap_word_i;
        end else begin
          left_o  <= stage_q;
          right_o <= cap_word_i;
          valid_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int DATA_W      = 24,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        fmt_i,
  input  logic              sck_i,
  input  logic              ws_i,
  input  logic              sd_i,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o,
  output logic              valid_o
);
  logic              bit_rise, ws_s, sd_s;
  logic              cap, cap_left;
  logic [DATA_W-1:0] cap_word;

  serial_audio_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .sck_i (sck_i), .ws_i  (ws_i), .sd_i(sd_i),
    .rise_o(bit_rise), .ws_o(ws_s), .sd_o(sd_s)
  );

  serial_audio_rx_frame #(.DATA_W(DATA_W), .CNT_W(CNT_W)) frame_i (
    .clk_i     (clk_i), .rst_ni(rst_ni),
    .bit_en_i  (bit_rise), .ws_i(ws_s), .sd_i(sd_s), .fmt_i(fmt_i),
    .cap_o     (cap), .cap_left_o(cap_left), .cap_word_o(cap_word)
  );

  serial_audio_rx_out #(.DATA_W(DATA_W)) out_i (
    .clk_i     (clk_i), .rst_ni(rst_ni),
    .cap_i     (cap), .cap_left_i(cap_left), .cap_word_i(cap_word),
    .left_o    (left_o), .right_o(right_o), .valid_o(valid_o)
  );
endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
  parameter int DATA_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        fmt_i,
  input logic              bit_rise_i,
  input logic [DATA_W-1:0] left_i,
  input logic [DATA_W-1:0] right_i,
  input logic              valid_i
);
  // R7
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  // R7
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ($stable(left_i) && $stable(right_i)));

  // R2
  valid_after_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $past(bit_rise_i));

  // R6
  zfill16_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fmt_i == 3'b000) |-> (left_i[7:0] == 8'h0 && right_i[7:0] == 8'h0));

  // R6
  zfill20_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fmt_i == 3'b001) |-> (left_i[3:0] == 4'h0 && right_i[3:0] == 4'h0));
endmodule

bind serial_audio_rx serial_audio_rx_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .fmt_i     (fmt_i),
  .bit_rise_i(bit_rise),
  .left_i    (left_o),
  .right_i   (right_o),
  .valid_i   (valid_o)
);

// File: tb/serial_audio_rx_tb_top.sv
`timescale 1ns/1ps
module serial_audio_rx_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sck = 1'b0, ws = 1'b0, sd = 1'b0;
  logic [2:0]  fmt = 3'b010;
  logic [23:0] left, right;
  logic        valid;

  always #2.5 clk = ~clk;

  serial_audio_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fmt_i(fmt),
    .sck_i(sck), .ws_i(ws), .sd_i(sd),
    .left_o(left), .right_o(right), .valid_o(valid)
  );

  int          checks = 0, errors = 0;
  bit          finished = 1'b0;
  string       cur_req = "R9";
  logic [47:0] exp_q[$];
  bit          ws_s[$];
  bit          sd_s[$];
  logic [23:0] prev_l = '0, prev_r = '0;
  bit          prev_v = 1'b0;

  task automatic chk(bit ok, string req, string what, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // per-clock reference comparison
  always @(negedge clk) begin
    logic [47:0] e;
    if (rst_n) begin
      if (valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R9", "strobe with no frame sent", left, 24'h0);
        else begin
          e = exp_q.pop_front();
          chk(left == e[47:24], cur_req, "R8 left word", left, e[47:24]);
          chk(right == e[23:0], cur_req, "right word", right, e[23:0]);
        end
        if (prev_v) chk(1'b0, "R7", "strobe longer than one cycle", 24'h1, 24'h0);
      end else if (left != prev_l || right != prev_r) begin
        chk(1'b0, "R7", "output changed without strobe", left, prev_l);
      end
    end
    prev_l = left; prev_r = right; prev_v = valid;
  end

  task automatic add_half(bit w, logic [23:0] d, int n, bit lsb, int h);
    for (int i = 0; i < h; i++) begin
      bit b;
      if (lsb) b = (i >= h - n) ? d[n-1-(i-(h-n))] : 1'($urandom_range(1));
      else     b = (i < n)      ? d[n-1-i]         : 1'($urandom_range(1));
      ws_s.push_back(w);
      sd_s.push_back(b);
    end
  endtask

  task automatic run_stream(logic [2:0] f, int h, int nframes, string req, bit pad16);
    bit          i2s = (f == 3'b011);
    bit          lsb = (f == 3'b000 || f == 3'b001 || f == 3'b100);
    int          n   = (f == 3'b000) ? 16 : (f == 3'b001) ? 20 : 24;
    bit          lw  = !i2s;
    logic [23:0] m   = (n == 24) ? 24'hFFFFFF : ((24'd1 << n) - 24'd1);
    @(negedge clk);
    rst_n = 1'b0; sck = 1'b0; fmt = f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; cur_req = req;
    ws_s.delete(); sd_s.delete();
    add_half(!lw, 24'($urandom) & m, n, lsb, h);      // partial lead-in, discarded (R9)
    for (int k = 0; k < nframes; k++) begin
      logic [23:0] dl, dr;
      dl = 24'($urandom) & m;
      dr = 24'($urandom) & m;
      if (k == 0) begin dl = 24'd1 << (n - 1); dr = (24'd1 << (n - 1)) - 24'd1; end
      if (pad16)  begin dl[7:0] = 8'h0; dr[7:0] = 8'h0; end
      exp_q.push_back({24'(dl << (24 - n)), 24'(dr << (24 - n))});
      add_half(lw, dl, n, lsb, h);
      add_half(!lw, dr, n, lsb, h);
    end
    add_half(lw, 24'($urandom) & m, n, lsb, h);       // closing edge for right-aligned capture
    for (int k = 0; k < ws_s.size(); k++) begin
      ws = ws_s[k];
      sd = i2s ? ((k == 0) ? 1'b0 : sd_s[k-1]) : sd_s[k];   // R4 one-bit delay
      repeat (4) @(negedge clk); sck = 1'b1;
      repeat (4) @(negedge clk); sck = 1'b0;
    end
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, req, "frames not delivered", 24'(exp_q.size()), 24'h0);
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9 reset state
    chk(left == 24'h0,  "R9", "reset left",  left,  24'h0);
    chk(right == 24'h0, "R9", "reset right", right, 24'h0);
    chk(valid == 1'b0,  "R9", "reset strobe", 24'(valid), 24'h0);
    // R1 R2 R3: left-aligned 24-bit, long and minimal half-frames, padded short words
    run_stream(3'b010, 32, 4, "R3", 1'b0);
    run_stream(3'b010, 24, 4, "R3", 1'b0);
    run_stream(3'b010, 32, 3, "R3", 1'b1);
    // R4: I2S, long half-frames and LSB spilling into the next half
    run_stream(3'b011, 32, 4, "R4", 1'b0);
    run_stream(3'b011, 24, 4, "R4", 1'b0);
    // R5 R6: right-aligned at minimal and padded half-frame lengths
    run_stream(3'b000, 16, 4, "R6", 1'b0);
    run_stream(3'b000, 32, 4, "R5", 1'b0);
    run_stream(3'b001, 20, 4, "R6", 1'b0);
    run_stream(3'b001, 32, 4, "R5", 1'b0);
    run_stream(3'b100, 24, 4, "R5", 1'b0);
    run_stream(3'b100, 32, 4, "R5", 1'b0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule